// File: doc/BRIEF.md
# Host Memory Access Port

This block is a slave port that lets an external host processor reach the on-chip program and data RAM with no help from the core. The host shares one 16-bit bus between addresses and data. It drives that bus with four strobes: chip select, address latch, read and write. The port answers on a single acknowledge line. First the host latches a word that sets either an overlay selection or a start address in one of the two memories. After that it streams reads or writes. The port steps the address after each one, so a block transfer needs only one address phase.

Data memory words are 16 bits wide, so each one moves in a single host access. Program memory words are 24 bits wide, so each one moves in two host accesses. The first carries the upper sixteen bits and the second carries the low byte in its bottom eight bits. All host strobes are resynchronised into the port clock. On the inside the port raises one request at a time to a single-port memory and waits for a grant. Writes aimed at the data memory window that holds the control registers are dropped. In boot mode the port also holds the core in reset until program word 0 has been written.

Top module: `hmp_port`

## Requirements
- R1: While reset is high, h_ack, m_req and h_ad_oe are 0 and ovl_sel is 0.
- R2: A latch word with bit 15 = 0 loads bits 13:0 as the start address. Bit 14 picks the target: 1 is program memory and 0 is data memory. The next data access uses that target and address.
- R3: A latch word with bit 15 = 1 and bits 14:8 all zero loads bits 7:0 into ovl_sel. It leaves the latched address and target as they were.
- R4: A latch word with bit 15 = 1 and any of bits 14:8 set is ignored. ovl_sel, the address and the target all stay unchanged.
- R5: The latched address goes up by one after each completed data memory access and after each completed pair of program memory halves. It wraps from 0x3FFF to 0x0000.
- R6: A program memory write takes the upper 16 bits from the first host write and bits 7:0 from the second host write. It makes exactly one memory write, and only after the second half.
- R7: A program memory read makes one memory read on the first host read and returns bits 23:8 of the word. The second host read returns {8'h00, bits 7:0} and makes no memory access.
- R8: A data memory write stores {8'h00, bus[15:0]}. A data memory read returns the low 16 bits of the word.
- R9: A data memory write whose address is at or above CTRL_BASE (default 0x3FE0) makes no memory request. The address still advances. Reads in that window are not blocked.
- R10: Once the port is idle and a strobe is raised, h_ack rises on the 4th rising clock edge if the access goes to memory and the grant comes at once. It rises on the 3rd edge for a latch, for a first program write half, for a second program read half and for a blocked write. h_ack stays high until the strobe is released, and the port raises no memory request while h_ack is high.
- R11: core_hold equals boot_mode until a program memory write to address 0 completes. From then on core_hold is 0.
- R12: Any latch cycle throws away a pending first half of a program word. The next program access starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| h_cs | input | 1 | Host chip select, active high, asynchronous |
| h_al | input | 1 | Host address-latch strobe, active high |
| h_rd | input | 1 | Host read strobe, active high |
| h_wr | input | 1 | Host write strobe, active high |
| h_ad_in | input | 16 | Host address/data bus, inbound |
| h_ad_out | output | 16 | Read data returned to the host |
| h_ad_oe | output | 1 | Drive enable for h_ad_out |
| h_ack | output | 1 | Current strobe has been served; low means ready for the next |
| boot_mode | input | 1 | Hold the core until program word 0 is written |
| core_hold | output | 1 | Keeps the core from executing |
| ovl_sel | output | 8 | Overlay selection register |
| m_req | output | 1 | Internal memory request |
| m_we | output | 1 | Request is a write |
| m_pm | output | 1 | Request targets program memory (1) or data memory (0) |
| m_addr | output | 14 | Latched word address |
| m_wdata | output | 24 | Write word |
| m_rdata | input | 24 | Read word, valid in the cycle of the grant |
| m_gnt | input | 1 | Memory grant; the request completes in this cycle |

## Verification
A strobe raised while the port is idle passes two synchroniser stages and one decode edge. If it needs memory it also spends one request cycle. So with an immediate grant, h_ack appears after four rising edges for a memory access and after three for a latch, a held half or a blocked write. The host model raises each strobe on a falling edge and counts rising edges until it sees h_ack on a falling edge. It compares that count with these figures. Only then does it read h_ad_out and drop the strobe. A scoreboard of expected memory requests, filled by the driver before each access, is matched on falling edges against each granted request. This catches a missing request, a request that should not occur, and a wrong address, target or word.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    localparam int BUS_W   = 16;
    localparam int ADDR_W  = 14;
    localparam int WORD_W  = 24;
    localparam int OVL_W   = 8;
    localparam int LO_W    = WORD_W - BUS_W;

    // bit positions inside the latch word that the decoder depends on
    localparam int KIND_BIT = 15;
    localparam int TGT_BIT  = 14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_MEM   = 2'd2,
        ST_DONE  = 2'd3
    } hmp_state_e;

    typedef enum logic {
        TGT_DM = 1'b0,
        TGT_PM = 1'b1
    } hmp_tgt_e;

    typedef struct packed {
        logic              is_ovl;
        logic              valid;
        hmp_tgt_e          tgt;
        logic [ADDR_W-1:0] addr;
        logic [OVL_W-1:0]  ovl;
    } latch_word_t;

    function automatic latch_word_t decode_latch(input logic [BUS_W-1:0] w);
        latch_word_t r;
        r.is_ovl = w[KIND_BIT];
        r.valid  = !w[KIND_BIT] || (w[TGT_BIT:OVL_W] == '0);
        r.tgt    = w[TGT_BIT] ? TGT_PM : TGT_DM;
        r.addr   = w[ADDR_W-1:0];
        r.ovl    = w[OVL_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[i-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/hmp_latch.sv
module hmp_latch
    import hmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                latch_stb,
    input  logic [BUS_W-1:0]    bus,
    input  logic                inc,
    output logic [ADDR_W-1:0]   addr,
    output hmp_tgt_e            tgt,
    output logic [OVL_W-1:0]    ovl
);

    latch_word_t dw;

    always_comb dw = decode_latch(bus);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            tgt  <= TGT_DM;
            ovl  <= '0;
        end else if (latch_stb) begin
            if (dw.valid) begin
                if (dw.is_ovl) begin
                    ovl <= dw.ovl;
                end else begin
                    addr <= dw.addr;
                    tgt  <= dw.tgt;
                end
            end
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
    import hmp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_cs,
    input  logic                s_al,
    input  logic                s_rd,
    input  logic                s_wr,
    input  logic [BUS_W-1:0]    bus,
    input  hmp_tgt_e            tgt,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                m_gnt,
    input  logic [WORD_W-1:0]   m_rdata,
    output logic                latch_stb,
    output logic                inc,
    output logic                ack,
    output logic                m_req,
    output logic                m_we,
    output logic [WORD_W-1:0]   m_wdata,
    output logic [BUS_W-1:0]    rd_data,
    output logic                rd_oe
);

    hmp_state_e          state;
    logic                al_q, rd_q, wr_q;
    logic                half;
    logic [BUS_W-1:0]    hold_hi;
    logic [LO_W-1:0]     low_byte;
    logic                we_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [BUS_W-1:0]    rdout;

    logic al_rise, rd_rise, wr_rise, is_pm, prot;

    always_comb begin
        al_rise = s_cs && s_al && !al_q;
        rd_rise = s_cs && s_rd && !rd_q && !s_wr;
        wr_rise = s_cs && s_wr && !wr_q && !s_rd;
        is_pm   = (tgt == TGT_PM);
        prot    = !is_pm && (addr >= CTRL_BASE);
    end

    always_comb begin
        latch_stb = (state == ST_LATCH) && !s_al;
        inc = 1'b0;
        if (state == ST_IDLE && !al_rise) begin
            if (wr_rise && prot)               inc = 1'b1;
            else if (rd_rise && is_pm && half) inc = 1'b1;
        end else if (state == ST_MEM && m_gnt) begin
            inc = we_q || !is_pm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            al_q <= 1'b0;
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            al_q <= s_al;
            rd_q <= s_rd;
            wr_q <= s_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            half     <= 1'b0;
            hold_hi  <= '0;
            low_byte <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            rdout    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (al_rise) begin
                        state <= ST_LATCH;
                    end else if (wr_rise) begin
                        if (is_pm && !half) begin
                            hold_hi <= bus;
                            half    <= 1'b1;
                            state   <= ST_DONE;
                        end else if (is_pm) begin
                            wdata_q <= {hold_hi, bus[LO_W-1:0]};
                            we_q    <= 1'b1;
                            state   <= ST_MEM;
                        end else if (prot) begin
                            state   <= ST_DONE;
                        end else begin
                            wdata_q <= {{LO_W{1'b0}}, bus};
                            we_q    <= 1'b1;
                            state   <= ST_MEM;
                        end
                    end else if (rd_rise) begin
                        if (is_pm && half) begin
                            rdout <= {{(BUS_W-LO_W){1'b0}}, low_byte};
                            half  <= 1'b0;
                            state <= ST_DONE;
                        end else begin
                            we_q  <= 1'b0;
                            state <= ST_MEM;
                        end
                    end
                end
                ST_MEM: begin
                    if (m_gnt) begin
                        if (we_q) begin
                            half <= 1'b0;
                        end else if (is_pm) begin
                            rdout    <= m_rdata[WORD_W-1:LO_W];
                            low_byte <= m_rdata[LO_W-1:0];
                            half     <= 1'b1;
                        end else begin
                            rdout <= m_rdata[BUS_W-1:0];
                        end
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!s_rd && !s_wr) state <= ST_IDLE;
                end
                ST_LATCH: begin
                    if (!s_al) begin
                        half  <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ack     = (state == ST_DONE) || (state == ST_LATCH);
    assign m_req   = (state == ST_MEM);
    assign m_we    = we_q;
    assign m_wdata = wdata_q;
    assign rd_data = rdout;
    assign rd_oe   = (state == ST_DONE) && s_rd;

endmodule

// File: rtl/hmp_port.sv
module hmp_port
    import hmp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_BASE   = 14'h3FE0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                h_cs,
    input  logic                h_al,
    input  logic                h_rd,
    input  logic                h_wr,
    input  logic [BUS_W-1:0]    h_ad_in,
    output logic [BUS_W-1:0]    h_ad_out,
    output logic                h_ad_oe,
    output logic                h_ack,
    input  logic                boot_mode,
    output logic                core_hold,
    output logic [OVL_W-1:0]    ovl_sel,
    output logic                m_req,
    output logic                m_we,
    output logic                m_pm,
    output logic [ADDR_W-1:0]   m_addr,
    output logic [WORD_W-1:0]   m_wdata,
    input  logic [WORD_W-1:0]   m_rdata,
    input  logic                m_gnt
);

    localparam int N_STROBES = 4;

    logic [N_STROBES-1:0] strobe_raw, strobe_s;
    logic                 latch_stb, inc;
    hmp_tgt_e             tgt;
    logic                 pm0_done;

    assign strobe_raw = {h_cs, h_al, h_rd, h_wr};

    hmp_sync #(
        .WIDTH  (N_STROBES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (strobe_raw),
        .q   (strobe_s)
    );

    hmp_latch latch_i (
        .clk       (clk),
        .rst       (rst),
        .latch_stb (latch_stb),
        .bus       (h_ad_in),
        .inc       (inc),
        .addr      (m_addr),
        .tgt       (tgt),
        .ovl       (ovl_sel)
    );

    hmp_ctrl #(
        .CTRL_BASE (CTRL_BASE)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .s_cs      (strobe_s[3]),
        .s_al      (strobe_s[2]),
        .s_rd      (strobe_s[1]),
        .s_wr      (strobe_s[0]),
        .bus       (h_ad_in),
        .tgt       (tgt),
        .addr      (m_addr),
        .m_gnt     (m_gnt),
        .m_rdata   (m_rdata),
        .latch_stb (latch_stb),
        .inc       (inc),
        .ack       (h_ack),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_wdata   (m_wdata),
        .rd_data   (h_ad_out),
        .rd_oe     (h_ad_oe)
    );

    assign m_pm = (tgt == TGT_PM);

    always_ff @(posedge clk) begin
        if (rst)
            pm0_done <= 1'b0;
        else if (m_req && m_gnt && m_we && m_pm && (m_addr == '0))
            pm0_done <= 1'b1;
    end

    assign core_hold = boot_mode && !pm0_done;

endmodule

// File: rtl/hmp_port_chk.sv
module hmp_port_chk
    import hmp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
    input logic              clk,
    input logic              rst,
    input logic              h_ack,
    input logic              m_req,
    input logic              m_gnt,
    input logic              m_we,
    input logic              m_pm,
    input logic [ADDR_W-1:0] m_addr,
    input logic              boot_mode,
    input logic              core_hold
);

    // R10: no memory traffic while the host is being acknowledged
    assert_req_not_acked_R10: assert property (@(posedge clk) disable iff (rst)
        m_req |-> !h_ack);

    // R10: a request is held until it is granted
    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_gnt) |=> m_req);

    // R9: no data memory write into the control window
    assert_no_ctrl_write_R9: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we && !m_pm) |-> (m_addr < CTRL_BASE));

    // R5: completed word access steps the address
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_gnt && (m_we || !m_pm)) |=> (m_addr == $past(m_addr) + 1'b1));

    // R11: hold release only after program word 0 is committed
    assert_hold_release_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_hold) && boot_mode && $past(boot_mode)) |->
            $past(m_req && m_gnt && m_we && m_pm && (m_addr == '0)));

    // R11: no hold outside boot mode
    assert_no_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !boot_mode |-> !core_hold);

endmodule

bind hmp_port hmp_port_chk #(.CTRL_BASE(CTRL_BASE)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .h_ack     (h_ack),
    .m_req     (m_req),
    .m_gnt     (m_gnt),
    .m_we      (m_we),
    .m_pm      (m_pm),
    .m_addr    (m_addr),
    .boot_mode (boot_mode),
    .core_hold (core_hold)
);

// File: tb/hmp_port_tb.sv
module hmp_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int OP_LATCH = 0;
    localparam int OP_WRITE = 1;
    localparam int OP_READ  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_cs = 1'b0, h_al = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
    logic [15:0] h_ad_in = '0;
    logic [15:0] h_ad_out;
    logic        h_ad_oe, h_ack;
    logic        boot_mode = 1'b0;
    logic        core_hold;
    logic [7:0]  ovl_sel;
    logic        m_req, m_we, m_pm;
    logic [13:0] m_addr;
    logic [23:0] m_wdata;
    logic [23:0] m_rdata = '0;
    logic        m_gnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign m_gnt = m_req;

    hmp_port dut_i (
        .clk (clk), .rst (rst),
        .h_cs (h_cs), .h_al (h_al), .h_rd (h_rd), .h_wr (h_wr),
        .h_ad_in (h_ad_in), .h_ad_out (h_ad_out), .h_ad_oe (h_ad_oe),
        .h_ack (h_ack), .boot_mode (boot_mode), .core_hold (core_hold),
        .ovl_sel (ovl_sel), .m_req (m_req), .m_we (m_we), .m_pm (m_pm),
        .m_addr (m_addr), .m_wdata (m_wdata), .m_rdata (m_rdata),
        .m_gnt (m_gnt)
    );

    typedef struct {
        bit          we;
        bit          pm;
        logic [13:0] addr;
        logic [23:0] wdata;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [23:0] pm_mem[int];
    logic [23:0] dm_mem[int];

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_mem(input bit we, input bit pm, input logic [13:0] addr,
                              input logic [23:0] wdata, input string req);
        exp_t e;
        e.we = we; e.pm = pm; e.addr = addr; e.wdata = wdata; e.req = req;
        sb_q.push_back(e);
    endtask

    // behavioural RAM and scoreboard monitor
    always @(negedge clk) begin
        if (!rst && m_req && m_gnt) begin
            if (m_we) begin
                if (m_pm) pm_mem[int'(m_addr)] = m_wdata;
                else      dm_mem[int'(m_addr)] = m_wdata;
            end else begin
                if (m_pm) m_rdata = pm_mem.exists(int'(m_addr)) ? pm_mem[int'(m_addr)] : 24'h0;
                else      m_rdata = dm_mem.exists(int'(m_addr)) ? dm_mem[int'(m_addr)] : 24'h0;
            end
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected memory access actual=%0h expected=none", m_addr);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (m_we !== e.we || m_pm !== e.pm || m_addr !== e.addr ||
                    (e.we && m_wdata !== e.wdata)) begin
                    errors++;
                    $display("FAIL %s memory access actual=%0b/%0b/%0h/%0h expected=%0b/%0b/%0h/%0h",
                             e.req, m_we, m_pm, m_addr, m_wdata, e.we, e.pm, e.addr, e.wdata);
                end
            end
        end
    end

    task automatic host_op(input int kind, input logic [15:0] data,
                           output int lat, output logic [15:0] rdata);
        int n;
        @(negedge clk);
        h_ad_in = data;
        h_cs = 1'b1;
        if (kind == OP_LATCH)      h_al = 1'b1;
        else if (kind == OP_WRITE) h_wr = 1'b1;
        else                       h_rd = 1'b1;
        lat = 0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (h_ack) break;
            if (lat > 40) begin
                checks++; errors++;
                $display("FAIL R10 ack timeout actual=0 expected=1");
                break;
            end
        end
        rdata = h_ad_out;
        h_cs = 1'b0; h_al = 1'b0; h_rd = 1'b0; h_wr = 1'b0;
        n = 0;
        while (h_ack && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (h_ack) begin
            checks++; errors++;
            $display("FAIL R10 ack stuck actual=1 expected=0");
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int          lat;
        logic [15:0] rd;

        // reset state, boot hold follows boot_mode
        repeat (3) @(negedge clk);
        check_eq("R11", "core_hold without boot mode", {31'd0, core_hold}, 32'd0);
        boot_mode = 1'b1;
        @(negedge clk);
        check_eq("R11", "core_hold in boot mode", {31'd0, core_hold}, 32'd1);
        check_eq("R1", "ack in reset", {31'd0, h_ack}, 32'd0);
        check_eq("R1", "m_req in reset", {31'd0, m_req}, 32'd0);
        check_eq("R1", "oe in reset", {31'd0, h_ad_oe}, 32'd0);
        check_eq("R1", "ovl_sel in reset", {24'd0, ovl_sel}, 32'd0);
        rst = 1'b0;

        // R2 R8 R5: data memory block write then read back
        host_op(OP_LATCH, 16'h0010, lat, rd);
        check_eq("R10", "latch ack latency", lat, 3);
        expect_mem(1, 0, 14'h0010, 24'h001234, "R2");
        host_op(OP_WRITE, 16'h1234, lat, rd);
        check_eq("R10", "dm write ack latency", lat, 4);
        expect_mem(1, 0, 14'h0011, 24'h00BEEF, "R8");
        host_op(OP_WRITE, 16'hBEEF, lat, rd);
        expect_mem(1, 0, 14'h0012, 24'h000F0F, "R5");
        host_op(OP_WRITE, 16'h0F0F, lat, rd);
        host_op(OP_LATCH, 16'h0010, lat, rd);
        expect_mem(0, 0, 14'h0010, 24'h0, "R5");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R8", "dm read 0x10", rd, 16'h1234);
        check_eq("R10", "dm read ack latency", lat, 4);
        expect_mem(0, 0, 14'h0011, 24'h0, "R5");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R8", "dm read 0x11", rd, 16'hBEEF);
        expect_mem(0, 0, 14'h0012, 24'h0, "R5");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R5", "dm read 0x12", rd, 16'h0F0F);

        // R3: overlay capture leaves address alone
        host_op(OP_LATCH, 16'h80A5, lat, rd);
        check_eq("R3", "overlay captured", {24'd0, ovl_sel}, 32'hA5);
        expect_mem(1, 0, 14'h0013, 24'h000777, "R3");
        host_op(OP_WRITE, 16'h0777, lat, rd);

        // R4: malformed overlay word ignored
        host_op(OP_LATCH, 16'h813C, lat, rd);
        check_eq("R4", "overlay unchanged", {24'd0, ovl_sel}, 32'hA5);
        expect_mem(1, 0, 14'h0014, 24'h000888, "R4");
        host_op(OP_WRITE, 16'h0888, lat, rd);

        // R6 R5 R11: program words with wrap to address 0
        host_op(OP_LATCH, 16'h7FFF, lat, rd);
        host_op(OP_WRITE, 16'hABCD, lat, rd);
        check_eq("R10", "pm first half ack latency", lat, 3);
        expect_mem(1, 1, 14'h3FFF, 24'hABCDEF, "R6");
        host_op(OP_WRITE, 16'h55EF, lat, rd);
        check_eq("R11", "hold before word 0", {31'd0, core_hold}, 32'd1);
        host_op(OP_WRITE, 16'h1357, lat, rd);
        check_eq("R6", "hold after first half of word 0", {31'd0, core_hold}, 32'd1);
        expect_mem(1, 1, 14'h0000, 24'h135724, "R5");
        host_op(OP_WRITE, 16'h0024, lat, rd);
        check_eq("R11", "hold released", {31'd0, core_hold}, 32'd0);

        // R7: program read halves
        host_op(OP_LATCH, 16'h7FFF, lat, rd);
        expect_mem(0, 1, 14'h3FFF, 24'h0, "R7");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R7", "pm read upper", rd, 16'hABCD);
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R7", "pm read low byte", rd, 16'h00EF);
        check_eq("R10", "pm second read ack latency", lat, 3);
        expect_mem(0, 1, 14'h0000, 24'h0, "R5");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R5", "pm read after wrap", rd, 16'h1357);
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R7", "pm read low after wrap", rd, 16'h0024);

        // R9: control window writes dropped, address advances
        host_op(OP_LATCH, 16'h3FDF, lat, rd);
        expect_mem(1, 0, 14'h3FDF, 24'h000AAA, "R9");
        host_op(OP_WRITE, 16'h0AAA, lat, rd);
        host_op(OP_WRITE, 16'h0BBB, lat, rd);
        check_eq("R10", "blocked write ack latency", lat, 3);
        host_op(OP_WRITE, 16'h0CCC, lat, rd);
        host_op(OP_LATCH, 16'h3FDF, lat, rd);
        expect_mem(0, 0, 14'h3FDF, 24'h0, "R9");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R9", "write below window", rd, 16'h0AAA);
        expect_mem(0, 0, 14'h3FE0, 24'h0, "R9");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R9", "window word untouched", rd, 16'h0000);
        expect_mem(0, 0, 14'h3FE1, 24'h0, "R9");
        host_op(OP_READ, 16'h0, lat, rd);
        check_eq("R9", "next window word untouched", rd, 16'h0000);

        // R12: latch discards a pending first half
        host_op(OP_LATCH, 16'h4020, lat, rd);
        host_op(OP_WRITE, 16'h1111, lat, rd);
        host_op(OP_LATCH, 16'h4020, lat, rd);
        host_op(OP_WRITE, 16'h2222, lat, rd);
        check_eq("R12", "restarted pair held", lat, 3);
        expect_mem(1, 1, 14'h0020, 24'h222233, "R12");
        host_op(OP_WRITE, 16'h0033, lat, rd);

        repeat (4) @(negedge clk);
        check_eq("R6", "scoreboard drained", sb_q.size(), 0);
        summary();
    end

endmodule